// File: doc/BRIEF.md
# Throttle-Gated Trigger Decision Regulator

This block sits in the central readout supervisor and turns the per-crossing trigger inputs into a final accept or reject decision. Each readout board reports back-pressure through a group of throttle bits, one per sub-card. The block synchronizes these bits and reduces each group to a single per-board throttle. It then combines the boards into one throttle-active flag and latches the bunch crossing identifier (BXID) at the moment throttling began. The flag and the latched BXID together form the throttle word that is returned upstream.

For every crossing the block arbitrates among four inputs: a filling-scheme veto, a special (periodic or calibration) trigger request, the low-level physics decision, and the throttle state. While throttling is active, physics accepts become rejects, and each one is counted for dead-time accounting. Special triggers take priority over the physics decision and are not throttled. The veto overrides every other input. The resulting decision, trigger kind, calibration sub-type and BXID leave through a delay line, so each decision appears a fixed number of cycles after the crossing it belongs to.

Top module: `trig_rate_regulator`

## Requirements
- R1: `thr_board_o[b]` is the OR of input bits `throttle_i[b*SUB_PER_BOARD +: SUB_PER_BOARD]`. It reflects the inputs sampled SYNC_STAGES+1 clock edges earlier.
- R2: `thr_active_o` is the OR of all per-board throttles, with the same delay as R1.
- R3: On the edge where `thr_active_o` goes from 0 to 1, `thr_bxid_o` loads the `bxid_i` sampled on that edge. It then holds that value until the next such rise.
- R4: A physics accept (`phys_accept_i`=1, no special request, no veto) sampled while `thr_active_o` is 1 gives a reject with kind 0 (none). Without throttle it gives an accept with kind 1 (physics) and calibration field 0.
- R5: A special request (`special_req_i`=1, no veto) gives an accept with kind 2 (special) and `out_cal_o` equal to `special_type_i`. This holds whatever the physics input and the throttle state are.
- R6: `bx_veto_i`=1 gives a reject with kind 3 (veto) and calibration field 0, whatever the other inputs are. With no veto, no special request and no physics accept, the result is a reject with kind 0.
- R7: The decision for inputs sampled on edge k appears on `out_accept_o`, `out_kind_o`, `out_cal_o` and `out_bxid_o` right after edge k+LATENCY-1, with `out_bxid_o` equal to the sampled `bxid_i`.
- R8: `supp_count_o` increments by one for each physics accept suppressed under R4. It saturates at all ones and is otherwise unchanged.
- R9: While reset is held, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| throttle_i | input | N_BOARDS*SUB_PER_BOARD | Raw throttle bits, grouped per board |
| bxid_i | input | BXID_W | Current crossing identifier |
| phys_accept_i | input | 1 | Low-level physics accept for this crossing |
| special_req_i | input | 1 | Periodic/calibration trigger request |
| special_type_i | input | CAL_W | Calibration sub-type of the special request |
| bx_veto_i | input | 1 | Filling-scheme veto for this crossing |
| thr_board_o | output | N_BOARDS | Per-board combined throttle |
| thr_active_o | output | 1 | Any board throttling |
| thr_bxid_o | output | BXID_W | BXID at which throttling last started |
| out_accept_o | output | 1 | Delayed final accept |
| out_kind_o | output | 2 | Delayed trigger kind (0 none, 1 physics, 2 special, 3 veto) |
| out_cal_o | output | CAL_W | Delayed calibration sub-type |
| out_bxid_o | output | BXID_W | BXID the delayed decision belongs to |
| supp_count_o | output | CNT_W | Saturating count of throttle-suppressed accepts |

## Verification
The bench holds throttle on for bursts of random length while physics accepts, special requests and vetoes arrive together. This exercises the priority order. A design with the order wrong would throttle calibration triggers or let physics pass through a veto. It would also show up as a wrong kind code that is visible after the delay line. Throttle edges test the BXID capture: a design that reloads during throttle, or that captures one cycle off, shows a different `thr_bxid_o`. A long directed burst of throttled accepts drives the suppression counter past its maximum, so a counter that wraps is caught. Every output is compared each cycle, and this catches a delay line that is one stage too short or too long.

// File: rtl/trr_pkg.sv
package trr_pkg;
   typedef enum logic [1:0] {
      TK_NONE    = 2'd0,
      TK_PHYS    = 2'd1,
      TK_SPECIAL = 2'd2,
      TK_VETO    = 2'd3
   } trig_kind_e;
endpackage

// File: rtl/trr_throttle_front.sv
// Synchronizes raw throttle bits, reduces them per board and overall,
// and latches the crossing id on the rising edge of the overall flag.
module trr_throttle_front #(
   parameter int N_BOARDS      = 4,
   parameter int SUB_PER_BOARD = 4,
   parameter int BXID_W        = 12,
   parameter int SYNC_STAGES   = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [N_BOARDS*SUB_PER_BOARD-1:0]  throttle_i,
   input  logic [BXID_W-1:0]                  bxid_i,
   output logic [N_BOARDS-1:0]                board_o,
   output logic                               active_o,
   output logic [BXID_W-1:0]                  bxid_o
);
   localparam int NT = N_BOARDS * SUB_PER_BOARD;

   logic [SYNC_STAGES-1:0][NT-1:0] sync_q;
   logic [N_BOARDS-1:0]            board_d;
   logic                           any_d;

   genvar s;
   generate
      for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= '0;
               else        sync_q[0] <= throttle_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= '0;
               else        sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   genvar b;
   generate
      for (b = 0; b < N_BOARDS; b++) begin : g_board
         assign board_d[b] = |sync_q[SYNC_STAGES-1][b*SUB_PER_BOARD +: SUB_PER_BOARD];
      end
   endgenerate

   assign any_d = |board_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         board_o  <= '0;
         active_o <= 1'b0;
         bxid_o   <= '0;
      end else begin
         board_o  <= board_d;
         active_o <= any_d;
         if (!active_o && any_d) bxid_o <= bxid_i;
      end
   end
endmodule

// File: rtl/trr_decider.sv
// Per-crossing priority: veto > special > physics (gated by throttle).
module trr_decider #(
   parameter int CAL_W = 4
) (
   input  logic              throttled_i,
   input  logic              phys_i,
   input  logic              special_i,
   input  logic [CAL_W-1:0]  cal_i,
   input  logic              veto_i,
   output logic              accept_o,
   output logic [1:0]        kind_o,
   output logic [CAL_W-1:0]  cal_o,
   output logic              suppress_o
);
   import trr_pkg::*;
   trig_kind_e kind;

   always_comb begin
      kind       = TK_NONE;
      cal_o      = '0;
      suppress_o = 1'b0;
      if (veto_i) begin
         kind = TK_VETO;
      end else if (special_i) begin
         kind  = TK_SPECIAL;
         cal_o = cal_i;
      end else if (phys_i) begin
         if (throttled_i) suppress_o = 1'b1;
         else             kind       = TK_PHYS;
      end
   end

   assign kind_o   = kind;
   assign accept_o = (kind == TK_PHYS) || (kind == TK_SPECIAL);
endmodule

// File: rtl/trr_sat_counter.sv
module trr_sat_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   output logic [W-1:0] count_o
);
   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      count_o <= '0;
      else if (inc_i && count_o != TOP) count_o <= count_o + 1'b1;
   end
endmodule

// File: rtl/trr_delay_line.sv
module trr_delay_line #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [DEPTH-1:0][W-1:0] stage_q;

   genvar i;
   generate
      for (i = 0; i < DEPTH; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= d_i;
            end
         end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[i] <= '0;
               else        stage_q[i] <= stage_q[i-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/trig_rate_regulator.sv
module trig_rate_regulator #(
   parameter int N_BOARDS      = 4,
   parameter int SUB_PER_BOARD = 4,
   parameter int BXID_W        = 12,
   parameter int CAL_W         = 4,
   parameter int LATENCY       = 16,
   parameter int SYNC_STAGES   = 2,
   parameter int CNT_W         = 16
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [N_BOARDS*SUB_PER_BOARD-1:0] throttle_i,
   input  logic [BXID_W-1:0]                 bxid_i,
   input  logic                              phys_accept_i,
   input  logic                              special_req_i,
   input  logic [CAL_W-1:0]                  special_type_i,
   input  logic                              bx_veto_i,
   output logic [N_BOARDS-1:0]               thr_board_o,
   output logic                              thr_active_o,
   output logic [BXID_W-1:0]                 thr_bxid_o,
   output logic                              out_accept_o,
   output logic [1:0]                        out_kind_o,
   output logic [CAL_W-1:0]                  out_cal_o,
   output logic [BXID_W-1:0]                 out_bxid_o,
   output logic [CNT_W-1:0]                  supp_count_o
);
   localparam int PIPE_W = 1 + 2 + CAL_W + BXID_W;

   generate
      if (LATENCY < 1) begin : g_bad_lat
         $error("LATENCY must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (N_BOARDS < 1 || SUB_PER_BOARD < 1) begin : g_bad_shape
         $error("board and sub-card counts must be positive");
      end
      if (CNT_W < 2 || BXID_W < 1 || CAL_W < 1) begin : g_bad_width
         $error("field widths out of range");
      end
   endgenerate

   logic              dec_accept;
   logic [1:0]        dec_kind;
   logic [CAL_W-1:0]  dec_cal;
   logic              dec_suppress;
   logic [PIPE_W-1:0] pipe_d, pipe_q;

   trr_throttle_front #(
      .N_BOARDS(N_BOARDS), .SUB_PER_BOARD(SUB_PER_BOARD),
      .BXID_W(BXID_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_front (
      .clk(clk), .rst_n(rst_n), .throttle_i(throttle_i), .bxid_i(bxid_i),
      .board_o(thr_board_o), .active_o(thr_active_o), .bxid_o(thr_bxid_o)
   );

   trr_decider #(.CAL_W(CAL_W)) u_dec (
      .throttled_i(thr_active_o), .phys_i(phys_accept_i),
      .special_i(special_req_i), .cal_i(special_type_i), .veto_i(bx_veto_i),
      .accept_o(dec_accept), .kind_o(dec_kind), .cal_o(dec_cal),
      .suppress_o(dec_suppress)
   );

   trr_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc_i(dec_suppress), .count_o(supp_count_o)
   );

   assign pipe_d = {dec_accept, dec_kind, dec_cal, bxid_i};

   trr_delay_line #(.W(PIPE_W), .DEPTH(LATENCY)) u_dly (
      .clk(clk), .rst_n(rst_n), .d_i(pipe_d), .q_o(pipe_q)
   );

   assign {out_accept_o, out_kind_o, out_cal_o, out_bxid_o} = pipe_q;
endmodule

// File: rtl/trr_checker.sv
module trr_checker #(
   parameter int BXID_W = 12,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [BXID_W-1:0] bxid_i,
   input logic              phys_accept_i,
   input logic              special_req_i,
   input logic              bx_veto_i,
   input logic              thr_active_o,
   input logic [BXID_W-1:0] thr_bxid_o,
   input logic              out_accept_o,
   input logic [1:0]        out_kind_o,
   input logic [CNT_W-1:0]  supp_count_o
);
   localparam logic [CNT_W-1:0] TOP = '1;
   logic supp;
   assign supp = thr_active_o && phys_accept_i && !special_req_i && !bx_veto_i;

   // R3
   a_r3_capture_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(thr_active_o) |-> thr_bxid_o == $past(bxid_i));
   // R3
   a_r3_hold_while_active: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(thr_active_o) && thr_active_o) |-> $stable(thr_bxid_o));
   // R8
   a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (supp && supp_count_o != TOP) |=> supp_count_o == $past(supp_count_o) + 1'b1);
   // R8
   a_r8_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !supp |=> $stable(supp_count_o));
   // R8
   a_r8_count_sat: assert property (@(posedge clk) disable iff (!rst_n)
      supp_count_o == TOP |=> supp_count_o == TOP);
   // R4 / R5 / R6
   a_r6_kind_matches_accept: assert property (@(posedge clk) disable iff (!rst_n)
      out_accept_o == (out_kind_o == 2'd1 || out_kind_o == 2'd2));
endmodule

bind trig_rate_regulator trr_checker #(.BXID_W(BXID_W), .CNT_W(CNT_W)) u_trr_chk (
   .clk(clk), .rst_n(rst_n), .bxid_i(bxid_i), .phys_accept_i(phys_accept_i),
   .special_req_i(special_req_i), .bx_veto_i(bx_veto_i),
   .thr_active_o(thr_active_o), .thr_bxid_o(thr_bxid_o),
   .out_accept_o(out_accept_o), .out_kind_o(out_kind_o),
   .supp_count_o(supp_count_o)
);

// File: tb/test_trig_rate_regulator.sv
module test_trig_rate_regulator;
   localparam int CLK_PERIOD = 10;
   localparam int NB   = 4;
   localparam int SUB  = 4;
   localparam int NT   = NB * SUB;
   localparam int BXW  = 12;
   localparam int CALW = 4;
   localparam int LAT  = 5;
   localparam int SYNC = 2;
   localparam int CW   = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NT-1:0]   throttle;
   logic [BXW-1:0]  bxid;
   logic            phys, spec, veto;
   logic [CALW-1:0] cal;
   logic [NB-1:0]   thr_board;
   logic            thr_active, out_acc;
   logic [BXW-1:0]  thr_bxid, out_bxid;
   logic [1:0]      out_kind;
   logic [CALW-1:0] out_cal;
   logic [CW-1:0]   cnt;

   always #(CLK_PERIOD/2) clk = ~clk;

   trig_rate_regulator #(
      .N_BOARDS(NB), .SUB_PER_BOARD(SUB), .BXID_W(BXW), .CAL_W(CALW),
      .LATENCY(LAT), .SYNC_STAGES(SYNC), .CNT_W(CW)
   ) i_trig_rate_regulator (
      .clk(clk), .rst_n(rst_n), .throttle_i(throttle), .bxid_i(bxid),
      .phys_accept_i(phys), .special_req_i(spec), .special_type_i(cal),
      .bx_veto_i(veto), .thr_board_o(thr_board), .thr_active_o(thr_active),
      .thr_bxid_o(thr_bxid), .out_accept_o(out_acc), .out_kind_o(out_kind),
      .out_cal_o(out_cal), .out_bxid_o(out_bxid), .supp_count_o(cnt)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   // reference model state (state after the most recent edge)
   logic [SYNC-1:0][NT-1:0]  m_sync;
   logic [NB-1:0]            m_board;
   logic                     m_act;
   logic [BXW-1:0]           m_bx;
   logic [CW-1:0]            m_cnt;
   logic [LAT-1:0]           m_acc;
   logic [LAT-1:0][1:0]      m_kind;
   logic [LAT-1:0][CALW-1:0] m_cal;
   logic [LAT-1:0][BXW-1:0]  m_obx;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // kind per requirements R4/R5/R6: 0 none, 1 physics, 2 special, 3 veto
   function automatic logic [1:0] exp_kind(input logic act, input logic p, input logic s, input logic v);
      if (v)      return 2'd3;
      if (s)      return 2'd2;
      if (p)      return act ? 2'd0 : 2'd1;
      return 2'd0;
   endfunction

   task automatic model_reset();
      m_sync = '0; m_board = '0; m_act = 0; m_bx = '0; m_cnt = '0;
      m_acc = '0; m_kind = '0; m_cal = '0; m_obx = '0;
   endtask

   task automatic model_step();
      logic [NB-1:0] nb;
      logic [1:0] k;
      for (int b = 0; b < NB; b++) nb[b] = |m_sync[SYNC-1][b*SUB +: SUB];
      k = exp_kind(m_act, phys, spec, veto);
      if (!veto && !spec && phys && m_act && m_cnt != '1) m_cnt = m_cnt + 1'b1;
      if (!m_act && |nb) m_bx = bxid;
      for (int i = LAT-1; i > 0; i--) begin
         m_acc[i] = m_acc[i-1]; m_kind[i] = m_kind[i-1];
         m_cal[i] = m_cal[i-1]; m_obx[i] = m_obx[i-1];
      end
      m_acc[0]  = (k == 2'd1 || k == 2'd2);
      m_kind[0] = k;
      m_cal[0]  = (k == 2'd2) ? cal : '0;
      m_obx[0]  = bxid;
      for (int i = SYNC-1; i > 0; i--) m_sync[i] = m_sync[i-1];
      m_sync[0] = throttle;
      m_board = nb;
      m_act   = |nb;
   endtask

   task automatic check_all();
      chk("R1", "thr_board",  32'(thr_board),  32'(m_board));
      chk("R2", "thr_active", 32'(thr_active), 32'(m_act));
      chk("R3", "thr_bxid",   32'(thr_bxid),   32'(m_bx));
      chk("R7", "out_accept", 32'(out_acc),    32'(m_acc[LAT-1]));
      chk("R4", "out_kind",   32'(out_kind),   32'(m_kind[LAT-1]));
      chk("R5", "out_cal",    32'(out_cal),    32'(m_cal[LAT-1]));
      chk("R7", "out_bxid",   32'(out_bxid),   32'(m_obx[LAT-1]));
      chk("R8", "supp_count", 32'(cnt),        32'(m_cnt));
   endtask

   task automatic cycle();
      @(negedge clk);
      check_all();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int thr_hold;
      logic [BXW-1:0] bxc;
      void'($urandom(32'd4242));
      throttle = '0; bxid = '0; phys = 0; spec = 0; veto = 0; cal = '0;
      model_reset();
      repeat (3) @(negedge clk);
      // R9: reset values
      chk("R9", "reset outputs", {thr_board, thr_active, out_acc, out_kind, out_cal},  '0);
      chk("R9", "reset bxids",   {thr_bxid, out_bxid}, '0);
      chk("R9", "reset count",   32'(cnt), 32'd0);
      rst_n = 1;
      bxc = '0;
      thr_hold = 0;
      // random phase
      for (int n = 0; n < 3000; n++) begin
         bxc = (bxc == 12'd3563) ? '0 : bxc + 1'b1;
         bxid = bxc;
         if (thr_hold == 0) begin
            thr_hold = 1 + ($urandom % 40);
            throttle = ($urandom % 2) ? NT'($urandom) & NT'($urandom) : '0;
         end else begin
            thr_hold--;
            if ($urandom % 8 == 0 && throttle != '0) throttle = NT'($urandom);
         end
         phys = ($urandom % 2);
         spec = ($urandom % 12 == 0);
         veto = ($urandom % 8 == 0);
         cal  = CALW'($urandom);
         model_step();
         cycle();
      end
      // directed: single sub-card on the last board, all priorities colliding
      throttle = '0; throttle[NT-1] = 1'b1;
      for (int n = 0; n < 12; n++) begin
         bxid = bxid + 1'b1;
         phys = 1; spec = (n % 3 == 1); veto = (n % 3 == 2); cal = 4'hA;
         model_step();
         cycle();
      end
      // directed: long throttled physics burst to saturate the counter (R8)
      for (int n = 0; n < 80; n++) begin
         bxid = bxid + 1'b1;
         phys = 1; spec = 0; veto = 0;
         model_step();
         cycle();
      end
      chk("R8", "saturated count", 32'(cnt), 32'((1 << CW) - 1));
      // release and drain
      throttle = '0; phys = 0;
      for (int n = 0; n < LAT + SYNC + 4; n++) begin
         bxid = bxid + 1'b1;
         model_step();
         cycle();
      end
      chk("R2", "released", 32'(thr_active), 32'd0);
      finish_run();
   end
endmodule